// File: doc/BRIEF.md
# Square-Root Staged Carry-Select Adder

This block is a purely combinational binary adder for 16-bit or 32-bit operands. It divides the operand bits into a chain of groups. The groups get wider toward the most significant end. The bottom group is a two-bit ripple adder fed by the external carry. Every higher group forms two candidate results side by side, one for an incoming carry of 0 and one for 1. It then takes the candidate chosen by the carry leaving the group below.

Because the upper groups are wider, each group's two candidates are ready at about the time its select carry arrives. The carry chain therefore passes through one multiplexer per group instead of one full adder per bit. A parent datapath uses the block wherever a single-cycle add with carry in and carry out is needed. The width parameter picks the group table, and any width other than 16 or 32 stops elaboration.

Top module: `sqrt_csel_adder`

## Requirements
- R1: With WIDTH = 16, `{cout_o, sum_o}` equals the 17-bit value `a_i + b_i + cin_i` for every input combination.
- R2: With WIDTH = 32, `{cout_o, sum_o}` equals the 33-bit value `a_i + b_i + cin_i` for every input combination.
- R3: The two least significant sum bits come from a ripple adder that takes `cin_i`. A carry in of 1 with zero operands gives a sum of 1, and a carry in of 1 with `a_i` = 3 and `b_i` = 0 gives a sum of 4.
- R4: With WIDTH = 16, the groups from least to most significant are 2, 2, 3, 4 and 5 bits wide. A carry made below each group boundary (bit 2, 4, 7 and 11) reaches the bit at that boundary.
- R5: With WIDTH = 32, the groups from least to most significant are 2, 2, 3, 4, 6, 7 and 8 bits wide. A carry made below each boundary (bit 2, 4, 7, 11, 17 and 24) reaches the bit at that boundary.
- R6: Each group above the lowest forms candidate results for incoming carries 0 and 1 and selects one of them with the carry from the group below. When a group's bits all propagate, its output flips between the two candidates as that carry changes.
- R7: The carry out of the most significant group is `cout_o`. All-ones `a_i` plus zero `b_i` plus a carry in of 1 gives a zero sum with `cout_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant group |

## Verification
The adder has no registers, so every result is due zero cycles after its operands change, once the combinational logic settles. The bench drives operands on the falling clock edge and compares the outputs one nanosecond later, well inside the same half cycle. The clock only paces the vectors and never gates a result. The comparisons cover both widths: sweeps over the low bits under several fixed upper patterns, carries forced across every group boundary, full-length propagation, and random operands.

// File: rtl/sqrt_csel_pkg.sv
`timescale 1ns/1ps
package sqrt_csel_pkg;

  // Number of groups (ripple base included) for a supported width.
  function automatic int grp_count(input int w);
    case (w)
      16:      return 5;
      32:      return 7;
      default: return 1;
    endcase
  endfunction

  // Width of group g, counted from the least significant end.
  function automatic int grp_width(input int w, input int g);
    int r;
    r = w;
    if (w == 16) begin
      case (g)
        0: r = 2; 1: r = 2; 2: r = 3; 3: r = 4; 4: r = 5;
        default: r = 0;
      endcase
    end else if (w == 32) begin
      case (g)
        0: r = 2; 1: r = 2; 2: r = 3; 3: r = 4;
        4: r = 6; 5: r = 7; 6: r = 8;
        default: r = 0;
      endcase
    end
    return r;
  endfunction

  // Bit position of the lowest bit of group g.
  function automatic int grp_lsb(input int w, input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += grp_width(w, i);
    return acc;
  endfunction

endpackage

// File: rtl/csel_full_add.sv
`timescale 1ns/1ps
module csel_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic prop;
  assign prop = x_i ^ y_i;
  assign s_o  = prop ^ c_i;
  assign c_o  = (x_i & y_i) | (prop & c_i);
endmodule

// File: rtl/csel_ripple.sv
`timescale 1ns/1ps
module csel_ripple #(
  parameter int N = 2
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         c_i,
  output logic [N-1:0] s_o,
  output logic         c_o
);
  logic [N:0] link;
  assign link[0] = c_i;

  for (genvar k = 0; k < N; k++) begin : g_bit
    csel_full_add u_fa (
      .x_i(x_i[k]), .y_i(y_i[k]), .c_i(link[k]),
      .s_o(s_o[k]), .c_o(link[k+1])
    );
  end

  assign c_o = link[N];

  always_comb begin
    if (!$isunknown({x_i, y_i, c_i, s_o, c_o})) begin
      // R3
      rca_sum_chk: assert ({c_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{N{1'b0}}, c_i}))
        else $error("ripple base result wrong");
    end
  end
endmodule

// File: rtl/csel_group.sv
`timescale 1ns/1ps
module csel_group #(
  parameter int N = 4
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         sel_i,
  output logic [N-1:0] s_o,
  output logic         c_o
);
  logic [N-1:0] half_s, half_c;
  logic [N-1:0] cy0, cy1, cy_pick;

  assign half_s = x_i ^ y_i;
  assign half_c = x_i & y_i;

  // Carry words for incoming carry 0 and 1.
  always_comb begin
    cy0[0] = half_c[0];
    cy1[0] = half_c[0] | half_s[0];
    for (int k = 1; k < N; k++) begin
      cy0[k] = half_c[k] | (half_s[k] & cy0[k-1]);
      cy1[k] = half_c[k] | (half_s[k] & cy1[k-1]);
    end
  end

  assign cy_pick = sel_i ? cy1 : cy0;

  // Final sum from half sums and selected carries.
  always_comb begin
    s_o[0] = half_s[0] ^ sel_i;
    for (int k = 1; k < N; k++) s_o[k] = half_s[k] ^ cy_pick[k-1];
  end

  assign c_o = cy_pick[N-1];

  always_comb begin
    if (!$isunknown({x_i, y_i, sel_i, cy0, cy1, s_o, c_o})) begin
      // R6
      cand_order_chk: assert ((cy0 & ~cy1) == '0)
        else $error("carry-0 candidate exceeds carry-1 candidate");
      // R6
      grp_sum_chk: assert ({c_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{N{1'b0}}, sel_i}))
        else $error("group result wrong");
    end
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
`timescale 1ns/1ps
module sqrt_csel_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  import sqrt_csel_pkg::*;

  localparam int NG = grp_count(WIDTH);

  if (!(WIDTH == 16 || WIDTH == 32)) begin : g_bad_width
    $error("sqrt_csel_adder: WIDTH must be 16 or 32");
  end

  logic [NG:0] chain;
  assign chain[0] = cin_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int GW  = grp_width(WIDTH, g);
    localparam int LSB = grp_lsb(WIDTH, g);
    if (g == 0) begin : g_base
      csel_ripple #(.N(GW)) u_base (
        .x_i(a_i[LSB +: GW]), .y_i(b_i[LSB +: GW]), .c_i(chain[g]),
        .s_o(sum_o[LSB +: GW]), .c_o(chain[g+1])
      );
    end else begin : g_sel
      csel_group #(.N(GW)) u_grp (
        .x_i(a_i[LSB +: GW]), .y_i(b_i[LSB +: GW]), .sel_i(chain[g]),
        .s_o(sum_o[LSB +: GW]), .c_o(chain[g+1])
      );
    end
  end

  assign cout_o = chain[NG];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i, sum_o, cout_o})) begin
      // R1 R2 R7
      total_sum_chk: assert ({cout_o, sum_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
        else $error("adder result wrong");
    end
  end
endmodule

// File: tb/sqrt_csel_adder_test.sv
`timescale 1ns/1ps
module sqrt_csel_adder_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [31:0] a32, b32, s32;
  logic        c32, co32;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  sqrt_csel_adder #(.WIDTH(16)) uut (
    .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16)
  );
  sqrt_csel_adder #(.WIDTH(32)) uut32 (
    .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32)
  );

  task automatic t16(input logic [15:0] a, input logic [15:0] b,
                     input logic c, input string req);
    logic [16:0] exp;
    @(negedge clk);
    a16 = a; b16 = b; c16 = c;
    #1;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
    vectors++;
    if ({co16, s16} !== exp) begin
      fails++;
      $display("FAIL %s: a=%h b=%h c=%b got %h exp %h", req, a, b, c, {co16, s16}, exp);
    end
  endtask

  task automatic t32(input logic [31:0] a, input logic [31:0] b,
                     input logic c, input string req);
    logic [32:0] exp;
    @(negedge clk);
    a32 = a; b32 = b; c32 = c;
    #1;
    exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
    vectors++;
    if ({co32, s32} !== exp) begin
      fails++;
      $display("FAIL %s: a=%h b=%h c=%b got %h exp %h", req, a, b, c, {co32, s32}, exp);
    end
  endtask

  initial begin
    int b16s[4];
    int b32s[6];
    int w16[5];
    int w32[7];
    logic [15:0] up16[4];
    logic [31:0] up32[4];
    b16s = '{2, 4, 7, 11};
    b32s = '{2, 4, 7, 11, 17, 24};
    w16  = '{2, 2, 3, 4, 5};
    w32  = '{2, 2, 3, 4, 6, 7, 8};
    up16 = '{16'h0000, 16'hFFF0, 16'hA5A0, 16'h5A50};
    up32 = '{32'h0, 32'hFFFF_FFF0, 32'hA5A5_A5A0, 32'h5A5A_5A50};
    a16 = '0; b16 = '0; c16 = 0; a32 = '0; b32 = '0; c32 = 0;

    // R1 R2: zero operands give zero
    t16(16'h0, 16'h0, 1'b0, "R1 zero");
    t32(32'h0, 32'h0, 1'b0, "R2 zero");

    // R3: carry into the ripple base
    t16(16'h0, 16'h0, 1'b1, "R3 cin only");
    t16(16'h3, 16'h0, 1'b1, "R3 base carry out");
    t32(32'h0, 32'h0, 1'b1, "R3 cin only 32");
    t32(32'h3, 32'h0, 1'b1, "R3 base carry out 32");

    // R1 R2: low-bit sweep under upper patterns
    for (int u = 0; u < 4; u++)
      for (int la = 0; la < 16; la++)
        for (int lb = 0; lb < 16; lb++)
          for (int c = 0; c < 2; c++) begin
            t16(up16[u] | 16'(la), up16[(u+1)%4] | 16'(lb), c[0], "R1 sweep");
            t32(up32[u] | 32'(la), up32[(u+3)%4] | 32'(lb), c[0], "R2 sweep");
          end

    // R4 R5: carries into each group boundary
    for (int i = 0; i < 4; i++) begin
      t16(16'((32'd1 << b16s[i]) - 1), 16'd1, 1'b0, "R4 boundary");
      t16(16'((32'd1 << b16s[i]) - 1), 16'd0, 1'b1, "R4 boundary cin");
    end
    for (int i = 0; i < 6; i++) begin
      t32(32'((64'd1 << b32s[i]) - 1), 32'd1, 1'b0, "R5 boundary");
      t32(32'((64'd1 << b32s[i]) - 1), 32'd0, 1'b1, "R5 boundary cin");
    end

    // R6: fully propagating group switches candidate with incoming carry
    begin
      int lsb;
      lsb = 0;
      for (int g = 0; g < 5; g++) begin
        lsb += w16[g];
        t16(16'((32'd1 << lsb) - 1), 16'd0, 1'b0, "R6 hold");
        t16(16'((32'd1 << lsb) - 1), 16'd0, 1'b1, "R6 flip");
      end
      lsb = 0;
      for (int g = 0; g < 7; g++) begin
        lsb += w32[g];
        t32(32'((64'd1 << lsb) - 1), 32'd0, 1'b0, "R6 hold 32");
        t32(32'((64'd1 << lsb) - 1), 32'd0, 1'b1, "R6 flip 32");
      end
    end

    // R7: full-length propagation to carry out
    t16(16'hFFFF, 16'h0000, 1'b1, "R7 all ones");
    t16(16'hFFFF, 16'hFFFF, 1'b1, "R7 max");
    t32(32'hFFFF_FFFF, 32'h0, 1'b1, "R7 all ones 32");
    t32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7 max 32");

    // R1 R2: random operands
    for (int n = 0; n < 3000; n++) begin
      t16(16'($urandom()), 16'($urandom()), 1'($urandom()), "R1 random");
      t32($urandom(), $urandom(), 1'($urandom()), "R2 random");
    end

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule